// File: doc/BRIEF.md
# Segment access-mode permission decoder

This block decides how a single memory access to an address segment is to be handled. It takes three inputs: the segment's 3-bit access-mode code, an enable bit that makes the error-level privilege unmapped, and the current privilege level. From these it gives one of three outcomes. The access is refused with an address error, it is sent through the TLB for translation, or it passes unmapped.

A caller presents the inputs together with a one-cycle valid strobe. The block registers the decision and shows it on the following cycle, with a valid flag for that cycle. Between strobes the last decision stays on the result port. The block does not translate addresses and does not hold the segment configuration; both stay with the caller.

Top module: `seg_access_decoder`

## Requirements
- R1: Result codes are 0 = unmapped, 1 = TLB-mapped and 2 = address error; code 3 never appears. Privilege codes are 0 = kernel, 1 = supervisor, 2 = user and 3 = error level.
- R2: In kernel mode no access mode gives an address error. Modes 1, 2 and 3 give TLB-mapped, and every other mode gives unmapped.
- R3: In supervisor mode, modes 0 and 1 give an address error, modes 2, 3 and 4 give TLB-mapped, and modes 5, 6 and 7 give unmapped.
- R4: In user mode, modes 0, 1, 2 and 5 give an address error, modes 3 and 4 give TLB-mapped, and modes 6 and 7 give unmapped.
- R5: At error level with the unmapped-enable bit at 1, every access mode gives unmapped. This override wins over the mapping that kernel rules would give.
- R6: At error level with the unmapped-enable bit at 0, every access mode gives the kernel-mode result.
- R7: Access modes 6 and 7 give unmapped at every privilege level and for both values of the enable bit.
- R8: The unmapped-enable bit has no effect on the result at privilege levels 0, 1 and 2.
- R9: Inputs are sampled on the clock edge where the strobe is 1. In the next cycle the valid output is 1 and the result output shows the decision. Back-to-back strobes give back-to-back results.
- R10: In a cycle after an edge where the strobe was 0, the valid output is 0 and the result output keeps its previous value, whatever the other inputs do.
- R11: Synchronous reset clears the valid output to 0 and the result output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe that samples the request inputs |
| in_mode | input | 3 | Segment access-mode code |
| in_eu | input | 1 | Makes error-level accesses unmapped when 1 |
| in_priv | input | 2 | Privilege level (0 kernel, 1 supervisor, 2 user, 3 error level) |
| out_valid | output | 1 | High for one cycle after each strobe |
| out_result | output | 2 | Decision code (0 unmapped, 1 TLB-mapped, 2 address error) |

## Verification
Two decisions can apply to the same request in one cycle. One pair is the error-level override and the kernel rule that would map modes 1 to 3. The other is a new strobe arriving in the very cycle the previous result is being shown. The bench sweeps all 64 combinations twice. The first pass uses isolated strobes, each followed by an idle cycle in which the inputs move but the result must not. The second pass uses continuous strobes. In both passes every result is judged against a mask computed in the bench, and at error level with the enable bit set the expected result is always unmapped.

// File: rtl/seg_access_pkg.sv
package seg_access_pkg;

    localparam int AM_W   = 3;
    localparam int NUM_AM = 1 << AM_W;

    typedef enum logic [1:0] {
        PRIV_KERN = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_USR  = 2'd2,
        PRIV_ERL  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        RES_UNMAP    = 2'd0,
        RES_TLB      = 2'd1,
        RES_ADDR_ERR = 2'd2
    } result_e;

    // one bit per access mode, bit index = mode code
    localparam logic [NUM_AM-1:0] KERN_MAP_M = 8'b0000_1110;
    localparam logic [NUM_AM-1:0] SUP_ERR_M  = 8'b0000_0011;
    localparam logic [NUM_AM-1:0] SUP_MAP_M  = 8'b0001_1100;
    localparam logic [NUM_AM-1:0] USR_ERR_M  = 8'b0010_0111;
    localparam logic [NUM_AM-1:0] USR_MAP_M  = 8'b0001_1000;
    // modes that are never mapped nor faulted
    localparam logic [NUM_AM-1:0] QUIET_M    = 8'b1100_0000;

    typedef struct packed {
        logic    vld;
        result_e res;
    } out_reg_t;

endpackage

// File: rtl/seg_mode_table.sv
module seg_mode_table
    import seg_access_pkg::*;
(
    input  priv_e             priv,
    input  logic              eu,
    output logic [NUM_AM-1:0] err_set,
    output logic [NUM_AM-1:0] map_set
);

    logic [NUM_AM-1:0] err_raw;
    logic [NUM_AM-1:0] map_raw;

    always_comb begin
        err_raw = '0;
        map_raw = '0;
        unique case (priv)
            PRIV_KERN: map_raw = KERN_MAP_M;
            PRIV_SUP: begin
                err_raw = SUP_ERR_M;
                map_raw = SUP_MAP_M;
            end
            PRIV_USR: begin
                err_raw = USR_ERR_M;
                map_raw = USR_MAP_M;
            end
            PRIV_ERL: map_raw = eu ? '0 : KERN_MAP_M;
            default: ;
        endcase
    end

    // per-mode gating of the quiet modes
    for (genvar m = 0; m < NUM_AM; m++) begin : g_mode
        assign err_set[m] = err_raw[m] & ~QUIET_M[m];
        assign map_set[m] = map_raw[m] & ~QUIET_M[m];
    end

endmodule

// File: rtl/seg_result_pick.sv
module seg_result_pick
    import seg_access_pkg::*;
(
    input  logic [NUM_AM-1:0] err_set,
    input  logic [NUM_AM-1:0] map_set,
    input  logic [AM_W-1:0]   mode,
    output result_e           res
);

    logic err_bit;
    logic map_bit;

    always_comb begin
        err_bit = err_set[mode];
        map_bit = map_set[mode];
        // address error outranks mapping
        if (err_bit)      res = RES_ADDR_ERR;
        else if (map_bit) res = RES_TLB;
        else              res = RES_UNMAP;
    end

endmodule

// File: rtl/seg_access_decoder.sv
module seg_access_decoder
    import seg_access_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [AM_W-1:0] in_mode,
    input  logic            in_eu,
    input  logic [1:0]      in_priv,
    output logic            out_valid,
    output logic [1:0]      out_result
);

    priv_e             priv_w;
    logic [NUM_AM-1:0] err_set_w;
    logic [NUM_AM-1:0] map_set_w;
    result_e           res_w;
    out_reg_t          st_d;
    out_reg_t          st_q;

    assign priv_w = priv_e'(in_priv);

    seg_mode_table u_table (
        .priv    (priv_w),
        .eu      (in_eu),
        .err_set (err_set_w),
        .map_set (map_set_w)
    );

    seg_result_pick u_pick (
        .err_set (err_set_w),
        .map_set (map_set_w),
        .mode    (in_mode),
        .res     (res_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.res = res_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld <= 1'b0;
            st_q.res <= RES_UNMAP;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == 2'd0));

    // R9
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        out_result != 2'd3);

    // R2
    kern_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_priv == 2'd0) |=> out_result != 2'd2);

    // R5
    erl_override_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_priv == 2'd3 && in_eu) |=> out_result == 2'd0);

    // R7
    quiet_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[2:1] == 2'b11) |=> out_result == 2'd0);

endmodule

// File: tb/seg_access_decoder_test.sv
module seg_access_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [2:0] in_mode;
    logic       in_eu;
    logic [1:0] in_priv;
    logic       out_valid;
    logic [1:0] out_result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_access_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_eu(in_eu), .in_priv(in_priv),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [1:0] expect_res(int p, int e, int m);
        int err_m;
        int map_m;
        err_m = 0;
        map_m = 0;
        if (p == 0 || (p == 3 && e == 0)) map_m = (1<<1)|(1<<2)|(1<<3);
        else if (p == 1) begin
            err_m = (1<<0)|(1<<1);
            map_m = (1<<2)|(1<<3)|(1<<4);
        end else if (p == 2) begin
            err_m = (1<<0)|(1<<1)|(1<<2)|(1<<5);
            map_m = (1<<3)|(1<<4);
        end
        if ((err_m >> m) & 1) return 2'd2;
        if ((map_m >> m) & 1) return 2'd1;
        return 2'd0;
    endfunction

    function automatic string tag_of(int p, int e, int m);
        if (m >= 6)           return "R7";
        if (p == 3 && e == 1) return "R5";
        if (p == 3)           return "R6";
        if (e == 1)           return "R8";
        if (p == 0)           return "R2";
        if (p == 1)           return "R3";
        return "R4";
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        logic [1:0] held;
        rst = 1'b1; in_valid = 1'b0; in_mode = '0; in_eu = 1'b0; in_priv = '0;
        repeat (3) @(negedge clk);
        // R11
        check("R11 valid", {1'b0, out_valid}, 2'd0);
        check("R11 result", out_result, 2'd0);
        rst = 1'b0;

        // isolated strobes with an idle cycle between
        for (int p = 0; p < 4; p++)
            for (int e = 0; e < 2; e++)
                for (int m = 0; m < 8; m++) begin
                    @(negedge clk);
                    in_valid = 1'b1; in_priv = 2'(p); in_eu = 1'(e); in_mode = 3'(m);
                    @(negedge clk);
                    in_valid = 1'b0;
                    check("R9 valid", {1'b0, out_valid}, 2'd1);
                    check(tag_of(p, e, m), out_result, expect_res(p, e, m));
                    check("R1 code", {1'b0, out_result == 2'd3}, 2'd0);
                    held = out_result;
                    // R10: move inputs without a strobe
                    in_priv = 2'(3 - p); in_eu = 1'(1 - e); in_mode = 3'(7 - m);
                    @(negedge clk);
                    check("R10 valid", {1'b0, out_valid}, 2'd0);
                    check("R10 hold", out_result, held);
                end

        // back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < 64; k++) begin
            in_priv = 2'(k >> 4); in_eu = 1'((k >> 3) & 1); in_mode = 3'(k & 7);
            @(negedge clk);
            check("R9 b2b valid", {1'b0, out_valid}, 2'd1);
            check("R9", out_result, expect_res(k >> 4, (k >> 3) & 1, k & 7));
        end
        in_valid = 1'b0;

        // R11: reset mid-run clears a nonzero result
        in_valid = 1'b1; in_priv = 2'd1; in_eu = 1'b0; in_mode = 3'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 pre-reset", out_result, 2'd2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 valid late", {1'b0, out_valid}, 2'd0);
        check("R11 result late", out_result, 2'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule